// File: doc/BRIEF.md
# PHY Bring-Up Sequencer

This block takes an Ethernet PHY from an unknown state to a negotiated link. It does so by issuing register transactions to an external management (MDIO) master over a simple request/done handshake. On a start request it sets the PHY's self-clearing reset bit and polls the control register until that bit drops. It then samples the status-output register once and writes an interrupt-enable mask and the ability advertisement. Finally it loops: it restarts autonegotiation at regular intervals and reads the status register until the acknowledge bit appears.

Every wait between steps is a whole number of delay units. One delay unit is a parameterised count of pulses on a millisecond tick input. When the sequence ends, the block reports either success or failure and holds that result until the next start request. It leaves decoding of the negotiated link mode to other logic.

Top module: `phy_bringup_seq`

## Requirements
- R1: A start pulse while the block is not busy raises busy. The first transaction is a write to register CTRL_REG with only bit RST_BIT set (0x8000 with defaults).
- R2: Every read of CTRL_REG during reset polling is preceded by exactly one delay unit, which is DELAY_TICKS tick pulses. Polling stops as soon as a read returns RST_BIT clear; all other bits of that read are ignored.
- R3: If a reset poll read returns RST_BIT still set and that read was the fifth poll (zero-based poll index above 3), the block ends with fail high and issues no further transactions.
- R4: After the reset bit clears, the block waits one delay unit and then reads register STATOUT_REG exactly once.
- R5: Next come two back-to-back writes with no delay between them. The first writes IMASK_VAL (eight enable bits, 0x00FF) to IMASK_REG. The second writes ADV_VAL (0x01E1: abilities at bits 8..5 plus selector 00001) to ADV_REG.
- R6: An iteration counter starts at 0. In each iteration whose count is a multiple of RESTART_PERIOD, the block first writes CTRL_REG with ANEN_BIT and ANRST_BIT set (0x1200 with defaults) and then waits two delay units.
- R7: Every iteration reads STAT_REG. If bit ACK_BIT of the returned value is set, the block ends with done high.
- R8: When the acknowledge bit is clear, the block waits three delay units and increments the counter. When the counter reaches ITER_LIMIT, the block ends with fail high.
- R9: While the block is busy, start is ignored. done and fail are never high together and hold their value, with busy low and no transactions, until the next start.
- R10: mgmt_start is a single-cycle pulse. No new request is issued until mgmt_done answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up sequence (ignored while busy) |
| tick | input | 1 | One-cycle pulse per millisecond |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence ended with negotiation acknowledged |
| fail | output | 1 | Sequence ended by reset or iteration timeout |
| mgmt_start | output | 1 | Request a management transaction |
| mgmt_write | output | 1 | 1 = write, 0 = read, valid with mgmt_start |
| mgmt_reg | output | 5 | PHY register number, valid with mgmt_start |
| mgmt_wdata | output | 16 | Write data, valid with mgmt_start |
| mgmt_done | input | 1 | Transaction finished; read data valid |
| mgmt_rdata | input | 16 | Data returned by a read |

## Verification
The bench builds the block with DELAY_TICKS=2, RESTART_PERIOD=8 and ITER_LIMIT=20, and sends one tick every third cycle. Reduced this way, the iteration timeout and three renegotiation restarts (iterations 0, 8 and 16) fit in a few hundred cycles. The gap in ticks before every transaction is measured against 2, 4 or 6. With the smaller limits, a stuck reset, a reset that clears on the last permitted poll, and an acknowledge that arrives right at a restart boundary can each be driven directly. Register numbers and bit positions stay at their defaults, so the written values can be compared against fixed constants.

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
  parameter int          DELAY_TICKS    = 1000,
  parameter logic [4:0]  CTRL_REG       = 5'd0,
  parameter logic [4:0]  STAT_REG       = 5'd1,
  parameter logic [4:0]  ADV_REG        = 5'd4,
  parameter logic [4:0]  STATOUT_REG    = 5'd18,
  parameter logic [4:0]  IMASK_REG      = 5'd19,
  parameter int          RST_BIT        = 15,
  parameter int          ANEN_BIT       = 12,
  parameter int          ANRST_BIT      = 9,
  parameter int          ACK_BIT        = 5,
  parameter logic [15:0] IMASK_VAL      = 16'h00FF,
  parameter logic [15:0] ADV_VAL        = 16'h01E1,
  parameter int          RST_POLL_LIMIT = 3,
  parameter int          ITER_LIMIT     = 1024,
  parameter int          RESTART_PERIOD = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        tick,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic        mgmt_start,
  output logic        mgmt_write,
  output logic [4:0]  mgmt_reg,
  output logic [15:0] mgmt_wdata,
  input  logic        mgmt_done,
  input  logic [15:0] mgmt_rdata
);
  localparam int DW = $clog2(3 * DELAY_TICKS + 1);
  localparam int IW = $clog2(ITER_LIMIT + 1);
  localparam int PW = $clog2(RESTART_PERIOD);
  localparam int RW = $clog2(RST_POLL_LIMIT + 2) + 1;
  localparam logic [DW-1:0] U1 = DW'(DELAY_TICKS);
  localparam logic [DW-1:0] U2 = DW'(2 * DELAY_TICKS);
  localparam logic [DW-1:0] U3 = DW'(3 * DELAY_TICKS);
  localparam logic [15:0] RST_WORD = 16'(1) << RST_BIT;
  localparam logic [15:0] AN_WORD  = (16'(1) << ANEN_BIT) | (16'(1) << ANRST_BIT);

  typedef enum logic [3:0] {
    S_IDLE, S_RST_WR, S_RST_DLY, S_RST_RD, S_SOR_DLY, S_SOR_RD, S_MSK_WR,
    S_ADV_WR, S_AN_WR, S_AN_DLY, S_ST_RD, S_GAP_DLY, S_OK, S_BAD
  } st_t;

  st_t           state;
  logic          sent;
  logic [DW-1:0] dly;
  logic [RW-1:0] rpoll;
  logic [IW-1:0] iter;
  logic [IW-1:0] iter_nx;
  logic          in_txn, is_dly, dly_end, ack;

  assign in_txn  = state inside {S_RST_WR, S_RST_RD, S_SOR_RD, S_MSK_WR, S_ADV_WR, S_AN_WR, S_ST_RD};
  assign is_dly  = state inside {S_RST_DLY, S_SOR_DLY, S_AN_DLY, S_GAP_DLY};
  assign dly_end = is_dly && tick && (dly == DW'(1));
  assign ack     = sent && mgmt_done;
  assign iter_nx = iter + IW'(1);

  assign mgmt_start = in_txn && !sent;
  assign mgmt_write = state inside {S_RST_WR, S_MSK_WR, S_ADV_WR, S_AN_WR};
  assign busy       = !(state inside {S_IDLE, S_OK, S_BAD});
  assign done       = (state == S_OK);
  assign fail       = (state == S_BAD);

  always_comb begin
    mgmt_reg   = CTRL_REG;
    mgmt_wdata = 16'h0000;
    case (state)
      S_RST_WR: mgmt_wdata = RST_WORD;
      S_SOR_RD: mgmt_reg   = STATOUT_REG;
      S_MSK_WR: begin mgmt_reg = IMASK_REG; mgmt_wdata = IMASK_VAL; end
      S_ADV_WR: begin mgmt_reg = ADV_REG;   mgmt_wdata = ADV_VAL;   end
      S_AN_WR:  mgmt_wdata = AN_WORD;
      S_ST_RD:  mgmt_reg   = STAT_REG;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sent  <= 1'b0;
      dly   <= '0;
      rpoll <= '0;
      iter  <= '0;
    end else begin
      if (mgmt_start) sent <= 1'b1;
      if (is_dly && tick && !dly_end) dly <= dly - DW'(1);
      case (state)
        S_IDLE, S_OK, S_BAD:
          if (start) begin
            state <= S_RST_WR;
            rpoll <= '0;
            iter  <= '0;
          end
        S_RST_WR:
          if (ack) begin sent <= 1'b0; state <= S_RST_DLY; dly <= U1; end
        S_RST_DLY:
          if (dly_end) state <= S_RST_RD;
        S_RST_RD:
          if (ack) begin
            sent  <= 1'b0;
            rpoll <= rpoll + RW'(1);
            dly   <= U1;
            if (!mgmt_rdata[RST_BIT])                  state <= S_SOR_DLY;
            else if (rpoll > RW'(RST_POLL_LIMIT))     state <= S_BAD;
            else                                       state <= S_RST_DLY;
          end
        S_SOR_DLY:
          if (dly_end) state <= S_SOR_RD;
        S_SOR_RD:
          if (ack) begin sent <= 1'b0; state <= S_MSK_WR; end
        S_MSK_WR:
          if (ack) begin sent <= 1'b0; state <= S_ADV_WR; end
        S_ADV_WR:
          if (ack) begin sent <= 1'b0; iter <= '0; state <= S_AN_WR; end
        S_AN_WR:
          if (ack) begin sent <= 1'b0; state <= S_AN_DLY; dly <= U2; end
        S_AN_DLY:
          if (dly_end) state <= S_ST_RD;
        S_ST_RD:
          if (ack) begin
            sent <= 1'b0;
            dly  <= U3;
            state <= mgmt_rdata[ACK_BIT] ? S_OK : S_GAP_DLY;
          end
        S_GAP_DLY:
          if (dly_end) begin
            iter <= iter_nx;
            if (iter_nx == IW'(ITER_LIMIT))      state <= S_BAD;
            else if (iter_nx[PW-1:0] == '0)      state <= S_AN_WR;
            else                                 state <= S_ST_RD;
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module phy_bringup_seq_chk #(
  parameter int IW = 11,
  parameter int ITER_LIMIT = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          mgmt_start,
  input logic          mgmt_done,
  input logic [IW-1:0] iter
);
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R1
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fail && !start) |=> fail); // R3
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n) iter <= IW'(ITER_LIMIT)); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done); // R9
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && fail)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mgmt_start); // R9
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mgmt_start |=> !mgmt_start); // R10
  AST_NO_START_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) mgmt_done |-> !mgmt_start); // R10
endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(.IW(IW), .ITER_LIMIT(ITER_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
  .mgmt_start(mgmt_start), .mgmt_done(mgmt_done), .iter(iter)
);

// File: tb/phy_bringup_seq_tb.sv
module phy_bringup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D     = 2;
  localparam int LIMIT = 20;
  localparam int PER   = 8;
  localparam int NSC   = 6;
  localparam int SC_RS [NSC] = '{0, 2, 4, 5, 0, 1};
  localparam int SC_AK [NSC] = '{0, 3, 1, 0, 8, 100};
  localparam bit SC_OK [NSC] = '{1, 1, 1, 0, 1, 0};

  logic clk = 0, rst_n = 0, start = 0, tick = 0;
  logic busy, done, fail, mgmt_start, mgmt_write, mgmt_done = 0;
  logic [4:0]  mgmt_reg;
  logic [15:0] mgmt_wdata, mgmt_rdata = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_bringup_seq #(.DELAY_TICKS(D), .ITER_LIMIT(LIMIT), .RESTART_PERIOD(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .busy(busy), .done(done),
    .fail(fail), .mgmt_start(mgmt_start), .mgmt_write(mgmt_write), .mgmt_reg(mgmt_reg),
    .mgmt_wdata(mgmt_wdata), .mgmt_done(mgmt_done), .mgmt_rdata(mgmt_rdata));

  int errs = 0, checks = 0;
  int rs_cfg = 0, ak_cfg = 0;
  logic clr = 0;
  int ln = 0, creads = 0, sreads = 0, tcnt = 0, lat = 0, tph = 0, overlap = 0;
  logic lw [128];
  logic [4:0] lreg [128];
  logic [15:0] ldata [128];
  int lgap [128];
  logic pw;
  logic [4:0] preg;

  always @(negedge clk) begin
    if (clr) begin ln = 0; creads = 0; sreads = 0; end
    if (mgmt_done) tcnt = 0; else if (tick) tcnt++;
    mgmt_done = 0;
    if (mgmt_start) begin
      if (lat != 0) overlap++;
      if (ln < 128) begin
        lw[ln] = mgmt_write; lreg[ln] = mgmt_reg; ldata[ln] = mgmt_wdata; lgap[ln] = tcnt;
      end
      ln++;
      pw = mgmt_write; preg = mgmt_reg; lat = 2;
    end else if (lat != 0) begin
      lat--;
      if (lat == 0) begin
        mgmt_done = 1;
        mgmt_rdata = 16'h0;
        if (!pw && preg == 5'd0) begin
          mgmt_rdata = (creads < rs_cfg) ? 16'hB140 : 16'h3140;
          creads++;
        end else if (!pw && preg == 5'd1) begin
          mgmt_rdata = (sreads >= ak_cfg) ? 16'h0024 : 16'hFFDF;
          sreads++;
        end else if (!pw) mgmt_rdata = 16'h5A5A;
      end
    end
    tick = (tph == 0);
    tph = (tph + 1) % 3;
  end

  logic e_w [128];
  logic [4:0] e_reg [128];
  logic [15:0] e_data [128];
  int e_gap [128];
  string e_tag [128];
  int en;
  bit e_ok;

  task automatic add(input logic w, input logic [4:0] r, input logic [15:0] dt, input int g, input string t);
    e_w[en] = w; e_reg[en] = r; e_data[en] = dt; e_gap[en] = g; e_tag[en] = t; en++;
  endtask

  task automatic build_exp(input int rs, input int ak);
    int pend;
    en = 0;
    add(1, 5'd0, 16'h8000, 0, "R1");
    for (int p = 0; ; p++) begin
      add(0, 5'd0, 16'h0, D, "R2");
      if (p >= rs) break;
      if (p > 3) begin e_ok = 0; return; end
    end
    add(0, 5'd18, 16'h0, D, "R4");
    add(1, 5'd19, 16'h00FF, 0, "R5");
    add(1, 5'd4, 16'h01E1, 0, "R5");
    pend = 0;
    for (int i = 0; ; i++) begin
      if (i == LIMIT) begin e_ok = 0; return; end
      if (i % PER == 0) begin add(1, 5'd0, 16'h1200, pend, "R6"); pend = 2*D; end
      add(0, 5'd1, 16'h0, pend, (pend == 3*D) ? "R8" : "R7");
      if (i >= ak) begin e_ok = 1; return; end
      pend = 3*D;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_end();
    int cyc = 0;
    while (!(done || fail) && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(cyc < 20000, "R9", "watchdog expired", cyc, 20000);
  endtask

  task automatic compare(input string endtag);
    chk(ln == en, endtag, "transaction count", ln, en);
    for (int k = 0; k < en && k < ln; k++) begin
      chk(lw[k] == e_w[k] && lreg[k] == e_reg[k] && (!e_w[k] || ldata[k] == e_data[k]),
          e_tag[k], $sformatf("txn %0d kind/reg/data", k),
          {15'd0, lw[k], 3'd0, lreg[k], ldata[k]}, {15'd0, e_w[k], 3'd0, e_reg[k], e_data[k]});
      if (k > 0) chk(lgap[k] == e_gap[k], e_tag[k], $sformatf("txn %0d tick gap", k), lgap[k], e_gap[k]);
    end
  endtask

  task automatic launch(input int rs, input int ak, input bit again);
    @(negedge clk); rs_cfg = rs; ak_cfg = ak; clr = 1;
    @(negedge clk); clr = 0; start = 1;
    @(negedge clk); start = 0;
    if (again) begin
      repeat (5) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
  endtask

  initial begin
    int hold_ln;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !mgmt_start, "R9", "reset outputs", {busy, done, fail, mgmt_start}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < NSC; s++) begin
      string etag;
      build_exp(SC_RS[s], SC_AK[s]);
      etag = SC_OK[s] ? "R7" : (SC_RS[s] > 4 ? "R3" : "R8");
      chk(e_ok == SC_OK[s], etag, "table vs model", e_ok, SC_OK[s]);
      launch(SC_RS[s], SC_AK[s], 0);
      wait_end();
      chk(done == SC_OK[s] && fail == !SC_OK[s] && !busy, etag, $sformatf("scenario %0d end flags", s),
          {done, fail, busy}, {SC_OK[s], !SC_OK[s], 1'b0});
      compare(etag);
    end
    // start ignored while busy, result held afterwards
    build_exp(1, 2);
    launch(1, 2, 1);
    wait_end();
    chk(done && !fail, "R9", "done after busy restart attempt", {done, fail}, 2);
    compare("R9");
    hold_ln = ln;
    repeat (30) @(negedge clk);
    chk(done && !busy && ln == hold_ln, "R9", "result held with no traffic", ln, hold_ln);
    chk(overlap == 0, "R10", "overlapping requests", overlap, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errs++; checks++;
    $display("FAIL R9 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule